// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Unit

This unit decides when the core leaves normal flow. Level-sensitive interrupt request lines are masked by an enable vector and a global enable bit. When at least one qualified request exists, the unit marks the next fetched instruction as an interrupt carrier and attaches the index of the winning line. That marker travels down the pipeline with the instruction. Interrupts are never taken asynchronously. They are resolved at writeback, together with illegal-instruction, breakpoint and environment-call faults.

At writeback the unit picks one action for the retiring instruction: a trap, a return from trap, or a normal commit. A trap or a return redirects fetch, pulses a kill, and flips an epoch bit. Younger instructions that still carry the old epoch reach writeback with their register-file and memory writes suppressed. Every trap goes to one fixed vector address. Handlers are told apart only by the cause value, and the saved PC and cause are written on the edge that closes the redirect cycle.

Top module: `trap_unit`

## Requirements
- R1: A committed interrupt writes a cause with bit 31 set and the low bits equal to the interrupt line index, which is also that line's bit position in the request and enable vectors. Lines 12 and 13 give 0x8000000C and 0x8000000D. A committed exception writes a cause with bit 31 clear.
- R2: Every trap drives redirect_o and kill_o high in its writeback cycle, with redirect_pc_o equal to the TVEC parameter (default 0x00000100), whatever the cause.
- R3: On the clock edge that ends a trap's redirect cycle, mepc_o takes wb_pc_i and mcause_o takes the cause.
- R4: The exception codes are 2 for illegal instruction, 3 for breakpoint and 11 for environment call. A carried interrupt takes precedence over all flags. Among the flags, illegal beats breakpoint, and breakpoint beats environment call.
- R5: fetch_irq_o is high in a cycle when all of the following hold: fetch_valid_i is high, gie_o is high, some bit of irq_i AND irq_en_i is set, and no carrier is in flight. fetch_irq_idx_o is then the highest such set index.
- R6: No carrier is produced while gie_o is low or while every requesting line is masked.
- R7: An instruction at writeback with wb_epoch_i different from fetch_epoch_o neither traps nor writes: wb_write_en_o and kill_o stay low. fetch_epoch_o toggles on every kill.
- R8: A live writeback with no flags, no carrier and no return raises wb_write_en_o and does not redirect.
- R9: Trap entry copies gie_o into mpie_o and clears gie_o.
- R10: A return at writeback restores gie_o from mpie_o, sets mpie_o, and redirects to mepc_o with kill_o high.
- R11: pending_o equals irq_i in every cycle.
- R12: At most one carrier is in flight. After a carrier is produced, no other is produced until the next kill.
- R13: After reset, gie_o equals the GIE_RST parameter (default 1), and mpie_o, mepc_o, mcause_o, fetch_epoch_o and kill_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NIRQ | Level interrupt requests |
| irq_en_i | input | NIRQ | Per-line enable mask |
| pending_o | output | NIRQ | Pending view of the request lines |
| fetch_valid_i | input | 1 | An instruction is fetched this cycle |
| fetch_irq_o | output | 1 | Marks the fetched instruction as an interrupt carrier |
| fetch_irq_idx_o | output | IW | Line index attached to the carrier |
| fetch_epoch_o | output | 1 | Current epoch, to be attached to fetched instructions |
| wb_valid_i | input | 1 | An instruction is at writeback |
| wb_epoch_i | input | 1 | Epoch carried by that instruction |
| wb_pc_i | input | XLEN | PC of that instruction |
| wb_illegal_i | input | 1 | Illegal-instruction flag |
| wb_ecall_i | input | 1 | Environment-call flag |
| wb_ebreak_i | input | 1 | Breakpoint flag |
| wb_mret_i | input | 1 | Return-from-trap instruction |
| wb_irq_i | input | 1 | Instruction is an interrupt carrier |
| wb_irq_idx_i | input | IW | Line index carried by the carrier |
| wb_write_en_o | output | 1 | Register and memory writes allowed |
| kill_o | output | 1 | Flush younger instructions |
| redirect_o | output | 1 | Redirect fetch |
| redirect_pc_o | output | XLEN | Redirect target |
| mepc_o | output | XLEN | Saved PC |
| mcause_o | output | XLEN | Trap cause |
| gie_o | output | 1 | Global interrupt enable |
| mpie_o | output | 1 | Previous interrupt enable |

## Verification
The hardest case to reach is a carrier that meets several requests at once while a previous carrier is still in flight. It needs the global enable restored by a return, several lines raised together, and fetch held active over two cycles, so that the in-flight guard and the highest-index choice are both visible. The stimulus takes a trap, returns from it, raises lines 3, 12 and 13 together, and probes fetch twice. It then retires the carrier with a stray illegal flag to confirm interrupt precedence. Stale-epoch suppression is reached by replaying an instruction with the pre-trap epoch right after a kill.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned CAUSE_ILLEGAL = 2;
  localparam int unsigned CAUSE_BREAK   = 3;
  localparam int unsigned CAUSE_ECALL_M = 11;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_TRAP,
    ACT_MRET
  } wb_act_e;
endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
  parameter int unsigned NIRQ = 16,
  localparam int unsigned IW = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] req_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o
);
  // ascending scan: last hit, i.e. highest index, wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/trap_decide.sv
module trap_decide
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IW   = 4
) (
  input  logic            wb_valid_i,
  input  logic            epoch_match_i,
  input  logic            illegal_i,
  input  logic            ecall_i,
  input  logic            ebreak_i,
  input  logic            mret_i,
  input  logic            irq_i,
  input  logic [IW-1:0]   irq_idx_i,
  output wb_act_e         act_o,
  output logic [XLEN-1:0] cause_o,
  output logic            write_en_o
);
  logic live;
  assign live = wb_valid_i & epoch_match_i;

  always_comb begin
    act_o      = ACT_NONE;
    cause_o    = '0;
    write_en_o = 1'b0;
    if (live) begin
      if (irq_i) begin
        act_o             = ACT_TRAP;
        cause_o[XLEN-1]   = 1'b1;
        cause_o[IW-1:0]   = irq_idx_i;
      end else if (illegal_i) begin
        act_o   = ACT_TRAP;
        cause_o = XLEN'(CAUSE_ILLEGAL);
      end else if (ebreak_i) begin
        act_o   = ACT_TRAP;
        cause_o = XLEN'(CAUSE_BREAK);
      end else if (ecall_i) begin
        act_o   = ACT_TRAP;
        cause_o = XLEN'(CAUSE_ECALL_M);
      end else if (mret_i) begin
        act_o = ACT_MRET;
      end else begin
        write_en_o = 1'b1;
      end
    end
  end

  always_comb begin
    a_r12_one_action: assert ($onehot0({act_o == ACT_TRAP, act_o == ACT_MRET, write_en_o}));
  end
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          GIE_RST = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  wb_act_e         act_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] wb_pc_i,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mcause_o,
  output logic            gie_o,
  output logic            mpie_o,
  output logic            epoch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mepc_o   <= '0;
      mcause_o <= '0;
      gie_o    <= GIE_RST;
      mpie_o   <= 1'b0;
      epoch_o  <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_TRAP: begin
          mepc_o   <= wb_pc_i;
          mcause_o <= cause_i;
          mpie_o   <= gie_o;
          gie_o    <= 1'b0;
          epoch_o  <= ~epoch_o;
        end
        ACT_MRET: begin
          gie_o   <= mpie_o;
          mpie_o  <= 1'b1;
          epoch_o <= ~epoch_o;
        end
        default: ;
      endcase
    end
  end

  a_r3_save_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_TRAP) |=> (mepc_o == $past(wb_pc_i)));
  a_r9_entry_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_TRAP) |=> (!gie_o && mpie_o == $past(gie_o)));
  a_r10_mret_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_MRET) |=> (gie_o == $past(mpie_o) && mpie_o));
  a_r7_epoch_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i != ACT_NONE) |=> (epoch_o != $past(epoch_o)));
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NIRQ    = 16,
  parameter logic [31:0] TVEC    = 32'h0000_0100,
  parameter bit          GIE_RST = 1'b1,
  localparam int unsigned IW     = $clog2(NIRQ)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] irq_i,
  input  logic [NIRQ-1:0] irq_en_i,
  output logic [NIRQ-1:0] pending_o,
  input  logic            fetch_valid_i,
  output logic            fetch_irq_o,
  output logic [IW-1:0]   fetch_irq_idx_o,
  output logic            fetch_epoch_o,
  input  logic            wb_valid_i,
  input  logic            wb_epoch_i,
  input  logic [XLEN-1:0] wb_pc_i,
  input  logic            wb_illegal_i,
  input  logic            wb_ecall_i,
  input  logic            wb_ebreak_i,
  input  logic            wb_mret_i,
  input  logic            wb_irq_i,
  input  logic [IW-1:0]   wb_irq_idx_i,
  output logic            wb_write_en_o,
  output logic            kill_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mcause_o,
  output logic            gie_o,
  output logic            mpie_o
);
  wb_act_e         act;
  logic [XLEN-1:0] cause;
  logic            irq_any;
  logic [IW-1:0]   irq_idx;
  logic            inflight_q;
  logic            tag;

  assign pending_o = irq_i;

  trap_irq_pick #(.NIRQ(NIRQ)) u_pick (
    .req_i (irq_i & irq_en_i),
    .any_o (irq_any),
    .idx_o (irq_idx)
  );

  trap_decide #(.XLEN(XLEN), .IW(IW)) u_decide (
    .wb_valid_i    (wb_valid_i),
    .epoch_match_i (wb_epoch_i == fetch_epoch_o),
    .illegal_i     (wb_illegal_i),
    .ecall_i       (wb_ecall_i),
    .ebreak_i      (wb_ebreak_i),
    .mret_i        (wb_mret_i),
    .irq_i         (wb_irq_i),
    .irq_idx_i     (wb_irq_idx_i),
    .act_o         (act),
    .cause_o       (cause),
    .write_en_o    (wb_write_en_o)
  );

  trap_state #(.XLEN(XLEN), .GIE_RST(GIE_RST)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act),
    .cause_i  (cause),
    .wb_pc_i  (wb_pc_i),
    .mepc_o   (mepc_o),
    .mcause_o (mcause_o),
    .gie_o    (gie_o),
    .mpie_o   (mpie_o),
    .epoch_o  (fetch_epoch_o)
  );

  // one carrier at a time; a kill squashes or retires it
  assign tag = fetch_valid_i & gie_o & irq_any & ~inflight_q & (act == ACT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               inflight_q <= 1'b0;
    else if (act != ACT_NONE)  inflight_q <= 1'b0;
    else if (tag)              inflight_q <= 1'b1;
  end

  assign fetch_irq_o     = tag;
  assign fetch_irq_idx_o = irq_idx;

  assign redirect_o    = (act != ACT_NONE);
  assign kill_o        = redirect_o;
  assign redirect_pc_o = (act == ACT_MRET) ? mepc_o : XLEN'(TVEC);

  a_r6_tag_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_irq_o |-> (gie_o && |(irq_i & irq_en_i)));
  a_r12_single_carrier: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_irq_o |=> !fetch_irq_o);
  a_r7_stale_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && wb_epoch_i != fetch_epoch_o) |-> (!wb_write_en_o && !kill_o));
  a_r5_idx_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_irq_o |-> (irq_i[fetch_irq_idx_o] && irq_en_i[fetch_irq_idx_o]));
endmodule

// File: tb/trap_unit_tb.sv
module trap_unit_tb;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NIRQ = 16;
  localparam int unsigned IW   = 4;
  localparam logic [31:0] TVEC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NIRQ-1:0] irq, irq_en, pending;
  logic fetch_valid, fetch_irq, fetch_epoch;
  logic [IW-1:0] fetch_idx;
  logic wb_valid, wb_epoch, wb_ill, wb_ecall, wb_ebreak, wb_mret, wb_irq;
  logic [XLEN-1:0] wb_pc;
  logic [IW-1:0] wb_idx;
  logic wb_we, kill, redirect, gie, mpie;
  logic [XLEN-1:0] redirect_pc, mepc, mcause;

  trap_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .irq_en_i(irq_en), .pending_o(pending),
    .fetch_valid_i(fetch_valid), .fetch_irq_o(fetch_irq), .fetch_irq_idx_o(fetch_idx),
    .fetch_epoch_o(fetch_epoch), .wb_valid_i(wb_valid), .wb_epoch_i(wb_epoch),
    .wb_pc_i(wb_pc), .wb_illegal_i(wb_ill), .wb_ecall_i(wb_ecall), .wb_ebreak_i(wb_ebreak),
    .wb_mret_i(wb_mret), .wb_irq_i(wb_irq), .wb_irq_idx_i(wb_idx), .wb_write_en_o(wb_we),
    .kill_o(kill), .redirect_o(redirect), .redirect_pc_o(redirect_pc), .mepc_o(mepc),
    .mcause_o(mcause), .gie_o(gie), .mpie_o(mpie)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] cause;
    bit              is_trap;
    string           req;
  } exp_t;
  exp_t expq[$];

  // bench-side model
  logic m_ep = 1'b0, m_gie = 1'b1, m_mpie = 1'b0;
  logic [XLEN-1:0] m_mepc = '0;

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wb_issue(logic [XLEN-1:0] pc, bit ill, bit ec, bit eb, bit mr,
                          bit iq, logic [IW-1:0] idx, logic ep);
    exp_t e;
    bit live = (ep == m_ep);
    @(negedge clk);
    wb_valid = 1'b1; wb_epoch = ep; wb_pc = pc; wb_ill = ill; wb_ecall = ec;
    wb_ebreak = eb; wb_mret = mr; wb_irq = iq; wb_idx = idx;
    if (live && (iq || ill || ec || eb)) begin
      e.target = TVEC; e.pc = pc; e.is_trap = 1'b1; e.req = "R2 R3 R4";
      if (iq)       e.cause = {1'b1, 27'd0, idx};
      else if (ill) e.cause = 32'd2;
      else if (eb)  e.cause = 32'd3;
      else          e.cause = 32'd11;
      expq.push_back(e);
      m_mepc = pc; m_mpie = m_gie; m_gie = 1'b0; m_ep = ~m_ep;
    end else if (live && mr) begin
      e.target = m_mepc; e.pc = pc; e.cause = '0; e.is_trap = 1'b0; e.req = "R10";
      expq.push_back(e);
      m_gie = m_mpie; m_mpie = 1'b1; m_ep = ~m_ep;
    end
    #2;
    check("R8 R7 write enable", {31'd0, wb_we}, {31'd0, live && !(iq||ill||ec||eb||mr)});
    if (!live) check("R7 stale no kill", {31'd0, kill}, 32'd0);
    @(negedge clk);
    wb_valid = 1'b0; wb_ill = 0; wb_ecall = 0; wb_ebreak = 0; wb_mret = 0; wb_irq = 0;
  endtask

  // monitor: pops expected redirects, checks target then saved state
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #2;
      if (redirect === 1'b1) begin
        if (expq.size() == 0) begin
          check("R2 unexpected redirect", {31'd0, redirect}, 32'd0);
        end else begin
          e = expq.pop_front();
          check({e.req, " target"}, redirect_pc, e.target);
          check("R2 kill", {31'd0, kill}, 32'd1);
          @(negedge clk); #2;
          if (e.is_trap) begin
            check("R3 mepc", mepc, e.pc);
            check("R1 R4 mcause", mcause, e.cause);
            check("R9 gie cleared", {30'd0, gie, mpie}, {30'd0, 1'b0, m_mpie});
          end else begin
            check("R10 gie restored", {30'd0, gie, mpie}, {30'd0, m_gie, 1'b1});
          end
          check("R7 epoch", {31'd0, fetch_epoch}, {31'd0, m_ep});
        end
      end
    end
  end

  task automatic fetch_probe(bit exp_tag, logic [IW-1:0] exp_idx, string req);
    @(negedge clk);
    fetch_valid = 1'b1;
    #2;
    check(req, {31'd0, fetch_irq}, {31'd0, exp_tag});
    if (exp_tag) check({req, " idx"}, {28'd0, fetch_idx}, {28'd0, exp_idx});
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    irq = '0; irq_en = '0; fetch_valid = 0; wb_valid = 0; wb_epoch = 0; wb_pc = '0;
    wb_ill = 0; wb_ecall = 0; wb_ebreak = 0; wb_mret = 0; wb_irq = 0; wb_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R13 reset state
    check("R13 gie", {31'd0, gie}, 32'd1);
    check("R13 mpie", {31'd0, mpie}, 32'd0);
    check("R13 mepc", mepc, 32'd0);
    check("R13 mcause", mcause, 32'd0);
    check("R13 epoch kill", {30'd0, fetch_epoch, kill}, 32'd0);

    wb_issue(32'h0000_0800, 0, 0, 0, 0, 0, '0, m_ep);   // R8 plain commit
    wb_issue(32'h0000_1000, 1, 0, 0, 0, 0, '0, m_ep);   // illegal
    wb_issue(32'h0000_1004, 1, 0, 0, 0, 0, '0, ~m_ep);  // R7 stale

    irq = 16'h0020; irq_en = '1;
    @(negedge clk); #2;
    check("R11 pending", {16'd0, pending}, {16'd0, irq});
    fetch_probe(0, '0, "R6 gie low blocks");
    irq = '0;

    wb_issue(32'h0000_1008, 0, 0, 0, 1, 0, '0, m_ep);   // R10 mret
    wb_issue(32'h0000_2000, 0, 1, 0, 0, 0, '0, m_ep);   // ecall 11
    wb_issue(32'h0000_2004, 0, 0, 0, 1, 0, '0, m_ep);
    wb_issue(32'h0000_2008, 0, 1, 1, 0, 0, '0, m_ep);   // R4 ebreak over ecall
    wb_issue(32'h0000_200c, 0, 0, 0, 1, 0, '0, m_ep);
    wb_issue(32'h0000_2010, 1, 0, 1, 0, 0, '0, m_ep);   // R4 illegal over ebreak
    wb_issue(32'h0000_2014, 0, 0, 0, 1, 0, '0, m_ep);

    irq = 16'h3008; irq_en = '1;
    fetch_probe(1, 4'd13, "R5 highest index");
    fetch_probe(0, '0, "R12 one in flight");
    @(negedge clk); #2;
    check("R11 pending multi", {16'd0, pending}, {16'd0, irq});
    wb_issue(32'h0000_3000, 1, 0, 0, 0, 1, 4'd13, m_ep); // R1 0x8000000D, carrier wins
    wb_issue(32'h0000_3004, 0, 0, 0, 1, 0, '0, m_ep);
    irq_en = 16'h1008;
    fetch_probe(1, 4'd12, "R5 masked line skipped");
    wb_issue(32'h0000_3100, 0, 0, 0, 0, 1, 4'd12, m_ep); // R1 0x8000000C
    wb_issue(32'h0000_3104, 0, 0, 0, 1, 0, '0, m_ep);
    irq_en = '0;
    fetch_probe(0, '0, "R6 all masked");

    repeat (3) @(negedge clk);
    check("R2 R10 queue drained", expq.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule